// File: doc/BRIEF.md
# Hot-Swap Power-Up Sequencing Controller

This block is the digital timing and control core of a hot-swap supervisor. It receives comparator flags from analog circuitry (overvoltage, two undervoltage levels, gate fully on) and a fault level from a separate overcurrent block. It decides when the external pass transistor's gate may be driven and tells downstream power modules when the supply is good.

After reset the gate is held off for a fixed power-on delay. The gate is then enabled, and an insertion flag stays high until power good is first reached. Any overvoltage, any undervoltage on the comparator chosen by the battery-mode input, an overcurrent, or a manual reset held long enough turns the gate off. When the cause goes away the gate is driven again at once, with no new power-on delay, which gives a soft re-insertion. A two-bit select chooses the gate charge current, reported as a code in 10 µA steps.

All timing is counted in ticks of an internal one-microsecond strobe, derived from the clock by a parameter. Every asynchronous input passes through a two-flop synchronizer.

Top module: `hs_seq_ctrl`

## Requirements
- R1: After reset, gate_en stays 0, pgood_n 1, inrush 0 and gate_cur 0 for POR_US microseconds. After that the first turn-on attempt is made: gate_en goes to 1 when no fault is present.
- R2: When batt_mode is 0, uv_main_flag acts as the undervoltage fault and uv_batt_flag has no effect. When batt_mode is 1, the roles swap.
- R3: An overvoltage flag or the selected undervoltage flag at 1 drives gate_en to 0 and pgood_n to 1 on the third rising edge after the input changes (two synchronizer stages, then the state register).
- R4: pgood_n is 0 only while no overvoltage, undervoltage, overcurrent or manual-reset hold is active and gate_full is 1. If gate_full drops, pgood_n returns to 1 while gate_en stays 1.
- R5: While gate_en is 1, gate_cur gives the selected current in 10 µA units: cur_sel 00 gives 5, 01 gives 1, 10 gives 7 and 11 gives 15. While gate_en is 0, gate_cur is 0. A new selection shows within 3 clock cycles.
- R6: mr_n held low for at least MR_MIN_US microseconds forces gate_en to 0. A low pulse shorter than MR_MIN_US - 1 microseconds has no effect on gate_en or pgood_n.
- R7: When mr_n returns high after a forced turn-off, gate_en goes back to 1 within a few clock cycles, with no new power-on delay.
- R8: inrush goes to 1 when the power-on delay ends and goes to 0 when pgood_n first becomes 0. It never rises again until the next reset.
- R9: When an overvoltage or undervoltage fault clears and no other fault is active, gate_en returns to 1 without a new power-on delay.
- R10: oc_fault at 1 drives gate_en to 0 and pgood_n to 1. When oc_fault returns to 0, the gate is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on reset) |
| ov_flag | input | 1 | 1 = input supply above overvoltage limit |
| uv_main_flag | input | 1 | 1 = supply below main undervoltage limit |
| uv_batt_flag | input | 1 | 1 = supply below battery undervoltage limit |
| batt_mode | input | 1 | 0 = main undervoltage used, 1 = battery undervoltage used |
| oc_fault | input | 1 | 1 = overcurrent reported by current monitor |
| gate_full | input | 1 | 1 = gate drive has reached its fully-on level |
| mr_n | input | 1 | Active-low manual reset request |
| cur_sel | input | 2 | Gate charge current select |
| gate_en | output | 1 | 1 = drive the pass transistor gate |
| gate_cur | output | 4 | Gate current in 10 µA units, 0 when off |
| pgood_n | output | 1 | Active-low power good |
| inrush | output | 1 | 1 during the first insertion ramp |

## Verification
The bench steps through the power-on delay on both sides of its end. A design that counted the wrong number of ticks, or let the gate run during the wait, would fail there. It swaps batt_mode with only the unselected undervoltage flag raised, so a design that ORs both flags or uses the wrong one drops the gate when it should not. Manual-reset pulses just shorter and clearly longer than the minimum expose a filter that reacts to glitches or never fires. Power-good and insertion flags are checked across a gate-full drop and repeated faults, to catch a power good that ignores the feedback or an insertion flag that rises again. A seeded random phase then mixes fault flags, battery mode and current selects, and checks gate enable, power good and current code against a bench model.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    typedef enum logic [1:0] {
        ST_POR_WAIT  = 2'd0,
        ST_RAMP      = 2'd1,
        ST_ON        = 2'd2,
        ST_FAULT_OFF = 2'd3
    } hs_state_e;

    // gate current select to current in 10 uA units
    function automatic logic [3:0] sel_to_cur(input logic [1:0] sel);
        logic [3:0] cur;
        case (sel)
            2'b00:   cur = 4'd5;
            2'b01:   cur = 4'd1;
            2'b10:   cur = 4'd7;
            default: cur = 4'd15;
        endcase
        return cur;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= RST_VAL;
            stable_q <= RST_VAL;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/hs_us_tick.sv
module hs_us_tick #(
    parameter int unsigned CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (CLKS_PER_US > 2) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_t;

    tick_t d, q;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tick |=> !q.tick);
endmodule

// File: rtl/hs_mr_filter.sv
module hs_mr_filter #(
    parameter int unsigned MR_MIN_US = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mr_low,
    output logic hold
);
    localparam int unsigned MW = $clog2(MR_MIN_US + 1);
    localparam logic [MW-1:0] LIMIT = MW'(MR_MIN_US);

    typedef struct packed {
        logic [MW-1:0] cnt;
        logic          hold;
    } mrf_t;

    mrf_t d, q;

    always_comb begin
        d = q;
        if (!mr_low) begin
            d.cnt  = '0;
            d.hold = 1'b0;
        end else if (!q.hold && tick) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt + 1'b1 == LIMIT) d.hold = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hold = q.hold;

    // R6
    mr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_low |=> !q.hold);

    // R6
    mr_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.hold) |-> $past(mr_low) && $past(tick));
endmodule

// File: rtl/hs_seq_ctrl.sv
module hs_seq_ctrl
    import hs_seq_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 100,
    parameter int unsigned POR_US      = 100000,
    parameter int unsigned MR_MIN_US   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ov_flag,
    input  logic       uv_main_flag,
    input  logic       uv_batt_flag,
    input  logic       batt_mode,
    input  logic       oc_fault,
    input  logic       gate_full,
    input  logic       mr_n,
    input  logic [1:0] cur_sel,
    output logic       gate_en,
    output logic [3:0] gate_cur,
    output logic       pgood_n,
    output logic       inrush
);
    localparam int unsigned POR_W    = $clog2(POR_US + 1);
    localparam logic [POR_W-1:0] POR_LAST = POR_W'(POR_US - 1);
    localparam int unsigned SW       = 9;
    localparam logic [SW-1:0] SYNC_RST = 9'b00_1_000000;

    typedef struct packed {
        hs_state_e        state;
        logic [POR_W-1:0] por_cnt;
        logic             gate_en;
        logic             pgood_n;
        logic             inrush;
        logic [3:0]       gate_cur;
    } ctl_t;

    ctl_t d, q;

    logic [SW-1:0] raw_in, syn;
    logic          tick, mr_hold;
    logic          ov_s, uvm_s, uvb_s, full_s, oc_s, batt_s, mr_n_s;
    logic [1:0]    sel_s;
    logic          uv_sel, ovuv_bad, trip;

    assign raw_in = {cur_sel, mr_n, batt_mode, oc_fault, gate_full,
                     uv_batt_flag, uv_main_flag, ov_flag};

    hs_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn)
    );

    assign {sel_s, mr_n_s, batt_s, oc_s, full_s, uvb_s, uvm_s, ov_s} = syn;

    hs_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    hs_mr_filter #(.MR_MIN_US(MR_MIN_US)) u_mrf (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mr_low(!mr_n_s), .hold(mr_hold)
    );

    assign uv_sel   = batt_s ? uvb_s : uvm_s;
    assign ovuv_bad = ov_s | uv_sel;
    assign trip     = ovuv_bad | oc_s | mr_hold;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_POR_WAIT: begin
                if (tick) begin
                    if (q.por_cnt == POR_LAST) begin
                        d.state  = trip ? ST_FAULT_OFF : ST_RAMP;
                        d.inrush = 1'b1;
                    end else begin
                        d.por_cnt = q.por_cnt + 1'b1;
                    end
                end
            end
            ST_RAMP: begin
                if (trip)        d.state = ST_FAULT_OFF;
                else if (full_s) d.state = ST_ON;
            end
            ST_ON: begin
                if (trip)         d.state = ST_FAULT_OFF;
                else if (!full_s) d.state = ST_RAMP;
            end
            ST_FAULT_OFF: begin
                if (!trip) d.state = ST_RAMP;
            end
            default: d.state = ST_FAULT_OFF;
        endcase

        d.gate_en  = (d.state == ST_RAMP) || (d.state == ST_ON);
        d.pgood_n  = (d.state != ST_ON);
        if (d.state == ST_ON) d.inrush = 1'b0;
        d.gate_cur = d.gate_en ? sel_to_cur(sel_s) : 4'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_POR_WAIT;
            q.pgood_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign gate_en  = q.gate_en;
    assign gate_cur = q.gate_cur;
    assign pgood_n  = q.pgood_n;
    assign inrush   = q.inrush;

    // R1
    por_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_POR_WAIT) |-> (!q.gate_en && q.pgood_n && q.gate_cur == 4'd0));

    // R3
    ovuv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovuv_bad |=> (!q.gate_en && q.pgood_n));

    // R10
    oc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_s |=> (!q.gate_en && q.pgood_n));

    // R6
    mr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr_hold |=> !q.gate_en);

    // R4
    pg_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pgood_n |-> (q.gate_en && $past(full_s)));

    // R8
    pg_inrush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pgood_n |-> !q.inrush);

    // R8
    inrush_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.inrush) |-> ($past(q.state) == ST_POR_WAIT));

    // R5
    cur_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.gate_en |-> (q.gate_cur == 4'd0));
endmodule

// File: tb/hs_seq_ctrl_test.sv
module hs_seq_ctrl_test;
    localparam int unsigned CPU   = 10;
    localparam int unsigned POR   = 50;
    localparam int unsigned MRMIN = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ov_flag = 1'b0, uv_main_flag = 1'b0, uv_batt_flag = 1'b0;
    logic       batt_mode = 1'b0, oc_fault = 1'b0, gate_full = 1'b0;
    logic       mr_n = 1'b1;
    logic [1:0] cur_sel = 2'b00;
    logic       gate_en, pgood_n, inrush;
    logic [3:0] gate_cur;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hs_seq_ctrl #(.CLKS_PER_US(CPU), .POR_US(POR), .MR_MIN_US(MRMIN)) uut (
        .clk(clk), .rst_n(rst_n), .ov_flag(ov_flag), .uv_main_flag(uv_main_flag),
        .uv_batt_flag(uv_batt_flag), .batt_mode(batt_mode), .oc_fault(oc_fault),
        .gate_full(gate_full), .mr_n(mr_n), .cur_sel(cur_sel),
        .gate_en(gate_en), .gate_cur(gate_cur), .pgood_n(pgood_n), .inrush(inrush)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_cur(input logic [1:0] s);
        case (s)
            2'b00:   return 5;
            2'b01:   return 1;
            2'b10:   return 7;
            default: return 15;
        endcase
    endfunction

    function automatic bit exp_ok(input bit ov, input bit uvm, input bit uvb,
                                  input bit bm, input bit oc);
        return !ov && !(bm ? uvb : uvm) && !oc;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 gate_en in reset", gate_en, 0);
        chk("R1 pgood_n in reset", pgood_n, 1);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 inrush after reset", inrush, 0);
        chk("R1 gate_cur after reset", gate_cur, 0);
        wait_cyc((POR - 3) * CPU);
        chk("R1 gate_en before delay end", gate_en, 0);
        chk("R8 inrush before delay end", inrush, 0);
        wait_cyc(6 * CPU);
        chk("R1 gate_en after delay", gate_en, 1);
        chk("R8 inrush during ramp", inrush, 1);
        chk("R5 gate_cur default select", gate_cur, 5);
        chk("R4 pgood_n without gate_full", pgood_n, 1);

        gate_full = 1'b1;
        wait_cyc(5);
        chk("R4 pgood_n asserted", pgood_n, 0);
        chk("R8 inrush cleared", inrush, 0);

        gate_full = 1'b0;
        wait_cyc(5);
        chk("R4 pgood_n after gate_full drop", pgood_n, 1);
        chk("R4 gate_en kept on gate_full drop", gate_en, 1);
        gate_full = 1'b1;
        wait_cyc(5);

        // R3 exact latency
        ov_flag = 1'b1;
        wait_cyc(2);
        chk("R3 gate_en one cycle early", gate_en, 1);
        wait_cyc(1);
        chk("R3 gate_en after overvoltage", gate_en, 0);
        chk("R3 pgood_n after overvoltage", pgood_n, 1);
        ov_flag = 1'b0;
        wait_cyc(6);
        chk("R9 gate_en after ov clear", gate_en, 1);
        chk("R9 pgood_n after ov clear", pgood_n, 0);
        chk("R8 inrush stays low", inrush, 0);

        // R2 undervoltage selection
        batt_mode = 1'b0; uv_batt_flag = 1'b1;
        wait_cyc(6);
        chk("R2 battery uv ignored in main mode", gate_en, 1);
        chk("R2 pgood kept in main mode", pgood_n, 0);
        uv_main_flag = 1'b1;
        wait_cyc(6);
        chk("R2 main uv trips in main mode", gate_en, 0);
        batt_mode = 1'b1; uv_batt_flag = 1'b0;
        wait_cyc(6);
        chk("R2 main uv ignored in battery mode", gate_en, 1);
        uv_batt_flag = 1'b1;
        wait_cyc(6);
        chk("R2 battery uv trips in battery mode", gate_en, 0);
        uv_batt_flag = 1'b0; uv_main_flag = 1'b0; batt_mode = 1'b0;
        wait_cyc(6);
        chk("R9 gate_en after uv clear", gate_en, 1);

        // R10 overcurrent
        oc_fault = 1'b1;
        wait_cyc(3);
        chk("R10 gate_en on overcurrent", gate_en, 0);
        chk("R10 pgood_n on overcurrent", pgood_n, 1);
        oc_fault = 1'b0;
        wait_cyc(6);
        chk("R10 gate_en after overcurrent clears", gate_en, 1);

        // R6 short manual reset pulse
        mr_n = 1'b0;
        wait_cyc(3 * CPU - 1);
        chk("R6 gate_en during short pulse", gate_en, 1);
        mr_n = 1'b1;
        wait_cyc(CPU);
        chk("R6 gate_en after short pulse", gate_en, 1);
        chk("R6 pgood_n after short pulse", pgood_n, 0);

        // R6 long pulse, R7 release
        mr_n = 1'b0;
        wait_cyc((MRMIN + 2) * CPU);
        chk("R6 gate_en during long pulse", gate_en, 0);
        chk("R6 gate_cur during long pulse", gate_cur, 0);
        mr_n = 1'b1;
        wait_cyc(6);
        chk("R7 gate_en after release", gate_en, 1);
        chk("R7 pgood_n after release", pgood_n, 0);

        // random phase: R2 R3 R5 R10
        for (int i = 0; i < 300; i++) begin
            bit ov, uvm, uvb, bm, oc, ok;
            logic [1:0] s;
            ov  = (($urandom % 5) == 0);
            uvm = (($urandom % 5) == 0);
            uvb = (($urandom % 5) == 0);
            oc  = (($urandom % 6) == 0);
            bm  = $urandom % 2;
            s   = 2'($urandom % 4);
            ov_flag = ov; uv_main_flag = uvm; uv_batt_flag = uvb;
            oc_fault = oc; batt_mode = bm; cur_sel = s;
            wait_cyc(6);
            ok = exp_ok(ov, uvm, uvb, bm, oc);
            chk("R3 random gate_en", gate_en, int'(ok));
            chk("R2 random pgood_n", pgood_n, int'(!ok));
            chk("R5 random gate_cur", gate_cur, ok ? exp_cur(s) : 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule